// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the register file of a multi-channel DMA layer, reached over a simple device-control-register bus. Each bus access carries a 10-bit register number, a read or write strobe and a 32-bit data word. The bank holds the global configuration, an error status word, the interrupt enables, and the channel-active words for each direction. It also holds the end-of-buffer and descriptor-error status words for transmit and receive, one descriptor table pointer per channel in each direction, and one buffer size per receive channel.

The DMA engine drives the five status words through per-bit set pulses. Software reads them and clears bits by writing ones. A configuration write with its top bit set acts as a software reset of the control and status state. It leaves the channel-active reset words, the table pointers and the buffer sizes untouched. Channel counts are parameters, and only the window slots for channels that exist are decoded.

Top module: `dma_ctl_regbank`

## Requirements
- R1: After rst_ni is released, configuration reads 0x0007C000, read data is zero, and error status, interrupt enable, both channel-active set words and the four channel status words read zero.
- R2: Register numbers: configuration 0x180, error status 0x181, interrupt enable 0x182, transmit active set/reset 0x184/0x185, transmit end-of-buffer 0x186, transmit descriptor error 0x187, receive active set/reset 0x190/0x191, receive end-of-buffer 0x192, receive descriptor error 0x193, transmit table pointer of channel i at 0x1A0+i, receive table pointer of channel i at 0x1C0+i, receive buffer size of channel i at 0x1E0+i.
- R3: Write masks: interrupt enable keeps bits [4:0], both transmit active words keep bits [31:28], both receive active words keep bits [31:30], buffer sizes keep bits [7:0], and table pointers keep all 32 bits. Masked-off bits read as zero.
- R4: A configuration write stores the written value ANDed with 0x00FFC087.
- R5: Error status and the four channel status words are write-one-to-clear: each 1 written clears that bit, and each 0 written leaves it.
- R6: Bit k of a status set input, pulsed for one cycle, sets bit k of its status word. Set inputs: err_set_i, tx_eob_set_i, tx_derr_set_i, rx_eob_set_i, rx_derr_set_i. When a set and a software clear hit the same bit in one cycle, the bit ends up set.
- R7: A configuration write with bit 31 set clears error status, interrupt enable, both active set words and the four status words. Configuration takes the masked written value. The active reset words, table pointers and buffer sizes keep their values.
- R8: A read of a register number that names no register and lies in no channel window returns zero.
- R9: Window slots at or beyond the configured channel count (TX_CH for transmit pointers, RX_CH for receive pointers and buffer sizes) read zero, and writes to them change no register.
- R10: Read data appears on rdata_o on the clock edge that samples rd_i. It holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_num_i | input | 10 | Register number of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_set_i | input | 32 | Per-bit set pulses for error status |
| tx_eob_set_i | input | 32 | Per-bit set pulses for transmit end-of-buffer status |
| tx_derr_set_i | input | 32 | Per-bit set pulses for transmit descriptor error status |
| rx_eob_set_i | input | 32 | Per-bit set pulses for receive end-of-buffer status |
| rx_derr_set_i | input | 32 | Per-bit set pulses for receive descriptor error status |

## Verification
The hardest case to reach from the ports is a status set pulse and a software clear landing on the same bit in the same cycle. The bench preloads two bits and then, at one falling edge, drives a clearing write of both bits together with a set pulse on one of them. It then reads back that only the pulsed bit survived. The software reset is reached the same way: every register class is preloaded first, and one configuration write then shows which classes cleared and which kept their data.

// File: rtl/dcr_bank_pkg.sv
package dcr_bank_pkg;
  localparam int unsigned NUM_W = 10;
  localparam int unsigned DW    = 32;
  localparam int unsigned NSTAT = 5;

  localparam logic [NUM_W-1:0] RN_CFG   = 10'h180;
  localparam logic [NUM_W-1:0] RN_ERR   = 10'h181;
  localparam logic [NUM_W-1:0] RN_IEN   = 10'h182;
  localparam logic [NUM_W-1:0] RN_TXSET = 10'h184;
  localparam logic [NUM_W-1:0] RN_TXRST = 10'h185;
  localparam logic [NUM_W-1:0] RN_TXEOB = 10'h186;
  localparam logic [NUM_W-1:0] RN_TXDER = 10'h187;
  localparam logic [NUM_W-1:0] RN_RXSET = 10'h190;
  localparam logic [NUM_W-1:0] RN_RXRST = 10'h191;
  localparam logic [NUM_W-1:0] RN_RXEOB = 10'h192;
  localparam logic [NUM_W-1:0] RN_RXDER = 10'h193;
  localparam logic [NUM_W-1:0] TXPTR_BASE = 10'h1A0;
  localparam logic [NUM_W-1:0] RXPTR_BASE = 10'h1C0;
  localparam logic [NUM_W-1:0] RXBUF_BASE = 10'h1E0;

  localparam logic [DW-1:0] CFG_RST   = 32'h0007_C000;
  localparam logic [DW-1:0] CFG_WMASK = 32'h00FF_C087;
  localparam logic [DW-1:0] IEN_WMASK = 32'h0000_001F;
  localparam logic [DW-1:0] TXA_WMASK = 32'hF000_0000;
  localparam logic [DW-1:0] RXA_WMASK = 32'hC000_0000;
  localparam int unsigned   BUF_W     = 8;
  localparam int unsigned   SRST_BIT  = 31;

  // status word order: err, tx_eob, tx_derr, rx_eob, rx_derr
  localparam logic [NUM_W-1:0] STAT_NUM [NSTAT] =
    '{RN_ERR, RN_TXEOB, RN_TXDER, RN_RXEOB, RN_RXDER};
endpackage

// File: rtl/w1c_status.sv
module w1c_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_clr_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] keep;

  always_comb begin
    keep = q_o;
    if (soft_clr_i)    keep = '0;
    else if (clr_wr_i) keep = q_o & ~wdata_i;
  end

  // hardware set has priority over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= keep | set_i;
  end
endmodule

// File: rtl/chan_window.sv
module chan_window #(
  parameter int unsigned      NCH    = 4,
  parameter int unsigned      KEEP_W = 32,
  parameter int unsigned      NUM_W  = 10,
  parameter logic [NUM_W-1:0] BASE   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_W-1:0]  reg_num_i,
  input  logic              wr_i,
  input  logic [KEEP_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [KEEP_W-1:0] rdata_o
);
  logic [NUM_W-1:0]  ofs;
  logic [KEEP_W-1:0] slot_q [NCH];

  assign ofs   = reg_num_i - BASE;
  assign hit_o = (reg_num_i >= BASE) && (ofs < NUM_W'(NCH));

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[i] <= '0;
      else if (wr_i && hit_o && ofs == NUM_W'(i))  slot_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (hit_o && ofs == NUM_W'(i)) rdata_o = slot_q[i];
  end
endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
  import dcr_bank_pkg::*;
#(
  parameter int unsigned TX_CH = 4,
  parameter int unsigned RX_CH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_W-1:0] reg_num_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [DW-1:0]    err_set_i,
  input  logic [DW-1:0]    tx_eob_set_i,
  input  logic [DW-1:0]    tx_derr_set_i,
  input  logic [DW-1:0]    rx_eob_set_i,
  input  logic [DW-1:0]    rx_derr_set_i
);
  logic          wr_cfg, soft_rst;
  logic [DW-1:0] cfg_q, ien_q, txcas_q, txcar_q, rxcas_q, rxcar_q;
  logic [DW-1:0] stat_set [NSTAT];
  logic [DW-1:0] stat_q   [NSTAT];
  logic [DW-1:0] err_q, tx_eob_q, tx_derr_q, rx_eob_q, rx_derr_q;

  assign wr_cfg   = wr_i && (reg_num_i == RN_CFG);
  assign soft_rst = wr_cfg && wdata_i[SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_RST;
    else if (wr_cfg) cfg_q <= wdata_i & CFG_WMASK;
  end

  // registers cleared by the software reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q   <= '0;
      txcas_q <= '0;
      rxcas_q <= '0;
    end else if (soft_rst) begin
      ien_q   <= '0;
      txcas_q <= '0;
      rxcas_q <= '0;
    end else if (wr_i) begin
      if (reg_num_i == RN_IEN)   ien_q   <= wdata_i & IEN_WMASK;
      if (reg_num_i == RN_TXSET) txcas_q <= wdata_i & TXA_WMASK;
      if (reg_num_i == RN_RXSET) rxcas_q <= wdata_i & RXA_WMASK;
    end
  end

  // registers kept across the software reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txcar_q <= '0;
      rxcar_q <= '0;
    end else if (wr_i) begin
      if (reg_num_i == RN_TXRST) txcar_q <= wdata_i & TXA_WMASK;
      if (reg_num_i == RN_RXRST) rxcar_q <= wdata_i & RXA_WMASK;
    end
  end

  assign stat_set[0] = err_set_i;
  assign stat_set[1] = tx_eob_set_i;
  assign stat_set[2] = tx_derr_set_i;
  assign stat_set[3] = rx_eob_set_i;
  assign stat_set[4] = rx_derr_set_i;

  for (genvar k = 0; k < NSTAT; k++) begin : g_stat
    w1c_status #(.W(DW)) u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .soft_clr_i(soft_rst),
      .clr_wr_i  (wr_i && (reg_num_i == STAT_NUM[k])),
      .wdata_i   (wdata_i),
      .set_i     (stat_set[k]),
      .q_o       (stat_q[k])
    );
  end

  assign err_q     = stat_q[0];
  assign tx_eob_q  = stat_q[1];
  assign tx_derr_q = stat_q[2];
  assign rx_eob_q  = stat_q[3];
  assign rx_derr_q = stat_q[4];

  logic             txp_hit, rxp_hit, rxb_hit;
  logic [DW-1:0]    txp_rd, rxp_rd;
  logic [BUF_W-1:0] rxb_rd;

  chan_window #(.NCH(TX_CH), .KEEP_W(DW), .NUM_W(NUM_W), .BASE(TXPTR_BASE)) u_txptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_num_i(reg_num_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .hit_o(txp_hit), .rdata_o(txp_rd)
  );

  chan_window #(.NCH(RX_CH), .KEEP_W(DW), .NUM_W(NUM_W), .BASE(RXPTR_BASE)) u_rxptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_num_i(reg_num_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .hit_o(rxp_hit), .rdata_o(rxp_rd)
  );

  chan_window #(.NCH(RX_CH), .KEEP_W(BUF_W), .NUM_W(NUM_W), .BASE(RXBUF_BASE)) u_rxbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_num_i(reg_num_i), .wr_i(wr_i),
    .wdata_i(wdata_i[BUF_W-1:0]), .hit_o(rxb_hit), .rdata_o(rxb_rd)
  );

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (txp_hit)      rd_mux = txp_rd;
    else if (rxp_hit) rd_mux = rxp_rd;
    else if (rxb_hit) rd_mux[BUF_W-1:0] = rxb_rd;
    else begin
      case (reg_num_i)
        RN_CFG:   rd_mux = cfg_q;
        RN_ERR:   rd_mux = err_q;
        RN_IEN:   rd_mux = ien_q;
        RN_TXSET: rd_mux = txcas_q;
        RN_TXRST: rd_mux = txcar_q;
        RN_TXEOB: rd_mux = tx_eob_q;
        RN_TXDER: rd_mux = tx_derr_q;
        RN_RXSET: rd_mux = rxcas_q;
        RN_RXRST: rd_mux = rxcar_q;
        RN_RXEOB: rd_mux = rx_eob_q;
        RN_RXDER: rd_mux = rx_derr_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/dma_ctl_regbank_chk.sv
module dma_ctl_regbank_chk
  import dcr_bank_pkg::*;
#(
  parameter int unsigned TX_CH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NUM_W-1:0] reg_num_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [DW-1:0]    tx_eob_set_i,
  input logic [DW-1:0]    rx_eob_set_i,
  input logic [DW-1:0]    cfg_q,
  input logic [DW-1:0]    ien_q,
  input logic [DW-1:0]    txcas_q,
  input logic [DW-1:0]    rxcas_q,
  input logic [DW-1:0]    tx_eob_q,
  input logic [DW-1:0]    rx_eob_q
);
  localparam logic [NUM_W-1:0] TX_BEYOND = TXPTR_BASE + NUM_W'(TX_CH);

  AST_IEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_num_i == RN_IEN) |=> ien_q == ($past(wdata_i) & 32'h0000_001F)); // R3

  AST_CFG_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_num_i == RN_CFG) |=> cfg_q == ($past(wdata_i) & 32'h00FF_C087)); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_num_i == RN_TXEOB && tx_eob_set_i == '0)
      |=> (tx_eob_q & $past(wdata_i)) == '0); // R5

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_eob_set_i != '0) |=> (rx_eob_q & $past(rx_eob_set_i)) == $past(rx_eob_set_i)); // R6

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_num_i == RN_CFG && wdata_i[31])
      |=> (ien_q == '0 && txcas_q == '0 && rxcas_q == '0)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && reg_num_i == 10'h183) |=> rdata_o == '0); // R8

  AST_BEYOND_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && TX_CH < 32 && reg_num_i == TX_BEYOND) |=> rdata_o == '0); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10
endmodule

bind dma_ctl_regbank dma_ctl_regbank_chk #(.TX_CH(TX_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_num_i   (reg_num_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .tx_eob_set_i(tx_eob_set_i),
  .rx_eob_set_i(rx_eob_set_i),
  .cfg_q       (cfg_q),
  .ien_q       (ien_q),
  .txcas_q     (txcas_q),
  .rxcas_q     (rxcas_q),
  .tx_eob_q    (tx_eob_q),
  .rx_eob_q    (rx_eob_q)
);

// File: tb/dma_ctl_regbank_tb.sv
`timescale 1ns/1ps
module dma_ctl_regbank_tb;
  localparam int TX_CH = 4;
  localparam int RX_CH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_num = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] err_set = '0, txe_set = '0, txd_set = '0, rxe_set = '0, rxd_set = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_ctl_regbank #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_num_i(reg_num), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .err_set_i(err_set), .tx_eob_set_i(txe_set),
    .tx_derr_set_i(txd_set), .rx_eob_set_i(rxe_set), .rx_derr_set_i(rxd_set)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] n, input logic [31:0] d);
    @(negedge clk);
    reg_num = n; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [9:0] n, output logic [31:0] d);
    @(negedge clk);
    reg_num = n; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] n, input logic [31:0] exp);
    logic [31:0] v;
    do_rd(n, v);
    chk(req, $sformatf("reg %h", n), v, exp);
  endtask

  task automatic pulse(input int which, input logic [31:0] v);
    @(negedge clk);
    case (which)
      0: err_set = v;
      1: txe_set = v;
      2: txd_set = v;
      3: rxe_set = v;
      default: rxd_set = v;
    endcase
    @(negedge clk);
    err_set = '0; txe_set = '0; txd_set = '0; rxe_set = '0; rxd_set = '0;
  endtask

  task automatic t_reset;
    chk("R1", "rdata after reset", rdata, 32'h0);
    rd_chk("R1", 10'h180, 32'h0007_C000);
    rd_chk("R1", 10'h181, 32'h0);
    rd_chk("R1", 10'h182, 32'h0);
    rd_chk("R1", 10'h184, 32'h0);
    rd_chk("R1", 10'h190, 32'h0);
    for (int k = 0; k < 4; k++)
      rd_chk("R1", (k < 2) ? 10'h186 + 10'(k) : 10'h192 + 10'(k - 2), 32'h0);
  endtask

  task automatic t_masks;
    do_wr(10'h182, 32'hFFFF_FFFF); rd_chk("R3", 10'h182, 32'h0000_001F);
    do_wr(10'h184, 32'hFFFF_FFFF); rd_chk("R3", 10'h184, 32'hF000_0000);
    do_wr(10'h185, 32'hFFFF_FFFF); rd_chk("R3", 10'h185, 32'hF000_0000);
    do_wr(10'h190, 32'hFFFF_FFFF); rd_chk("R3", 10'h190, 32'hC000_0000);
    do_wr(10'h191, 32'hFFFF_FFFF); rd_chk("R3", 10'h191, 32'hC000_0000);
    do_wr(10'h1E1, 32'hFFFF_FF5A); rd_chk("R3", 10'h1E1, 32'h0000_005A);
    do_wr(10'h180, 32'h7FFF_FFFF); rd_chk("R4", 10'h180, 32'h00FF_C087);
    // R2: distinct values in every pointer slot, no aliasing
    for (int i = 0; i < TX_CH; i++) do_wr(10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < RX_CH; i++) do_wr(10'h1C0 + 10'(i), 32'hC000_0100 + 32'(i));
    do_wr(10'h1E0, 32'h0000_0033);
    for (int i = 0; i < TX_CH; i++) rd_chk("R2", 10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < RX_CH; i++) rd_chk("R2", 10'h1C0 + 10'(i), 32'hC000_0100 + 32'(i));
    rd_chk("R2", 10'h1E0, 32'h0000_0033);
  endtask

  task automatic t_w1c;
    logic [9:0] nums [5] = '{10'h181, 10'h186, 10'h187, 10'h192, 10'h193};
    for (int k = 0; k < 5; k++) begin
      pulse(k, 32'h8000_000F);
      rd_chk("R6", nums[k], 32'h8000_000F);
      do_wr(nums[k], 32'h0000_0005);
      rd_chk("R5", nums[k], 32'h8000_000A);
      do_wr(nums[k], 32'hFFFF_FFFF);
      rd_chk("R5", nums[k], 32'h0);
    end
  endtask

  task automatic t_set_wins;
    pulse(3, 32'h0000_0003);
    @(negedge clk);
    reg_num = 10'h192; wdata = 32'h0000_0003; wr = 1'b1; rxe_set = 32'h0000_0001;
    @(negedge clk);
    wr = 1'b0; rxe_set = '0;
    rd_chk("R6", 10'h192, 32'h0000_0001);
  endtask

  task automatic t_soft_reset;
    do_wr(10'h182, 32'h0000_0015);
    do_wr(10'h184, 32'h9000_0000);
    do_wr(10'h185, 32'h5000_0000);
    do_wr(10'h190, 32'h8000_0000);
    do_wr(10'h191, 32'h4000_0000);
    do_wr(10'h1A1, 32'h1234_5678);
    do_wr(10'h1E1, 32'h0000_00C3);
    pulse(0, 32'h0000_0100);
    pulse(2, 32'h0000_0010);
    do_wr(10'h180, 32'h8000_0081);
    rd_chk("R7", 10'h180, 32'h0000_0081);
    rd_chk("R7", 10'h182, 32'h0);
    rd_chk("R7", 10'h184, 32'h0);
    rd_chk("R7", 10'h190, 32'h0);
    rd_chk("R7", 10'h181, 32'h0);
    rd_chk("R7", 10'h187, 32'h0);
    rd_chk("R7", 10'h185, 32'h5000_0000);
    rd_chk("R7", 10'h191, 32'h4000_0000);
    rd_chk("R7", 10'h1A1, 32'h1234_5678);
    rd_chk("R7", 10'h1E1, 32'h0000_00C3);
  endtask

  task automatic t_unmapped;
    rd_chk("R8", 10'h183, 32'h0);
    rd_chk("R8", 10'h1FF, 32'h0);
    rd_chk("R8", 10'h000, 32'h0);
    rd_chk("R8", 10'h194, 32'h0);
  endtask

  task automatic t_beyond;
    do_wr(10'h1A0, 32'h0BAD_0000);
    do_wr(10'h1A0 + 10'(TX_CH), 32'hFFFF_FFFF);
    do_wr(10'h1C0 + 10'(RX_CH), 32'hFFFF_FFFF);
    do_wr(10'h1E0 + 10'(RX_CH), 32'hFFFF_FFFF);
    rd_chk("R9", 10'h1A0 + 10'(TX_CH), 32'h0);
    rd_chk("R9", 10'h1C0 + 10'(RX_CH), 32'h0);
    rd_chk("R9", 10'h1E0 + 10'(RX_CH), 32'h0);
    rd_chk("R9", 10'h1A0, 32'h0BAD_0000);
    rd_chk("R9", 10'h1A0 + 10'(TX_CH - 1), 32'hA000_0000 + 32'(TX_CH - 1));
  endtask

  task automatic t_latency;
    do_wr(10'h182, 32'h0000_0003);
    rd_chk("R10", 10'h183, 32'h0);
    @(negedge clk);
    reg_num = 10'h182; rd = 1'b1;
    #1 chk("R10", "before edge", rdata, 32'h0);
    @(negedge clk);
    rd = 1'b0;
    chk("R10", "after edge", rdata, 32'h0000_0003);
    reg_num = 10'h180;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "hold without rd", rdata, 32'h0000_0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_w1c();
    t_set_wins();
    t_soft_reset();
    t_unmapped();
    t_beyond();
    t_latency();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule